// File: doc/BRIEF.md
# DS3 Far-End Alarm Code Transmitter

This block drives the far-end alarm and control (FEAC) bit that sits in each outbound DS3 frame. The surrounding framer asserts a one-cycle frame-slot strobe once per frame, and the block returns the bit value to place in that frame's FEAC slot. When no message is pending, every slot carries a 1. A run of ones is the idle message, and the block keeps sending it until the host asks for something else.

A small host register port lets software load a 6-bit alarm or command code, turn the transmitter on, and request a send. On a send request the block takes a copy of the code and wraps it in a 16-bit codeword. It shifts the codeword out one bit per strobe and sends it ten times in a row. After the last bit of the tenth copy it sets a sticky interrupt flag and goes back to idle ones. Reading the status register clears the interrupt flag.

Top module: `feac_tx`

## Requirements
- R1: After reset and whenever no transmission is in progress, each frame strobe sets `feac_bit` to 1. The reset value of `feac_bit` is 1.
- R2: Address 0 holds the code in data bits 5:0 and reads back what was written. Address 1 holds the enable flag in bit 0, which reads back. Writing address 1 with bit 1 set is a send request and does not read back. All registers reset to 0.
- R3: A send request made while the enable flag is 0 has no effect. The output stays at idle ones.
- R4: The codeword is sent in slot order k = 0..15. Slot 0 carries 0, slots 1..6 carry code bits 0..5, slot 7 carries 0, and slots 8..15 carry 1.
- R5: `feac_bit` changes only on a clock edge at which `frame_strobe` is high. Between strobes it holds its value, and the message resumes at the next strobe.
- R6: One send request produces exactly 10 back-to-back codewords (160 strobes). Later strobes return to idle ones.
- R7: Once the 160th bit has been sent, `irq` goes high within two clock cycles and stays high until the status register (address 2, bit 0) is read. That read returns 1 and clears the flag, so a second read returns 0.
- R8: The code is captured when the send request is accepted. Writes to address 0 during a transmission do not change the bits being sent.
- R9: A send request made while a transmission is in progress is discarded. It is not queued, so idle ones follow the current 10 codewords.
- R10: Writing 0 to the enable flag during a transmission stops it. Later strobes send 1, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 2 | Host register address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Registered host read data, valid the cycle after `rd_en` |
| frame_strobe | input | 1 | One pulse per outbound DS3 frame FEAC slot |
| feac_bit | output | 1 | Registered FEAC bit for the current frame |
| irq | output | 1 | Transmit-complete interrupt flag |

## Verification
The bench sends every one of the 64 codes and compares all 160 bits of each send against a codeword built arithmetically from the slot layout. A design with the wrong bit order or a wrong repeat count fails on exact slots. Mid-message pauses catch a design that advances without a strobe. A code rewrite plus a second send request in the middle of a message catches a design that reads the live register or queues the request, which would show up as wrong bits or as extra codewords in place of idle ones. The bench also targets a send request while disabled, an abort by clearing the enable flag, and the clear-on-read flag. A design that got these wrong would send an unwanted message, keep sending after an abort, or leave the interrupt stuck.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int CODE_W   = 6;
  localparam int ONES_W   = 8;
  localparam int CW_W     = CODE_W + 2 + ONES_W;
  localparam int REPEATS  = 10;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CODE = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_addr_t;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_START_BIT = 1;
endpackage

// File: rtl/feac_host_regs.sv
module feac_host_regs
  import feac_pkg::*;
#(
  parameter int CODE_WIDTH = CODE_W,
  parameter int DWIDTH     = DATA_W,
  parameter int AWIDTH     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AWIDTH-1:0] addr,
  input  logic [DWIDTH-1:0] wr_data,
  output logic [DWIDTH-1:0] rd_data,
  input  logic              done_i,
  output logic [CODE_WIDTH-1:0] code_o,
  output logic              enable_o,
  output logic              start_o,
  output logic              irq_o
);
  logic sel_code, sel_ctrl, sel_stat;
  assign sel_code = (addr == AWIDTH'(REG_CODE));
  assign sel_ctrl = (addr == AWIDTH'(REG_CTRL));
  assign sel_stat = (addr == AWIDTH'(REG_STAT));

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= '0;
      enable_o <= 1'b0;
      start_o  <= 1'b0;
    end else begin
      start_o <= wr_en && sel_ctrl && wr_data[CTRL_START_BIT];
      if (wr_en && sel_code) code_o   <= wr_data[CODE_WIDTH-1:0];
      if (wr_en && sel_ctrl) enable_o <= wr_data[CTRL_EN_BIT];
    end
  end

  // sticky completion flag; a new completion wins over a clearing read
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else if (done_i) begin
      irq_o <= 1'b1;
    end else if (rd_en && sel_stat) begin
      irq_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (sel_code)      rd_data <= DWIDTH'(code_o);
      else if (sel_ctrl) rd_data <= DWIDTH'(enable_o);
      else if (sel_stat) rd_data <= DWIDTH'(irq_o);
      else               rd_data <= '0;
    end
  end

  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    done_i |=> irq_o);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_stat && !done_i) |=> !irq_o);
endmodule

// File: rtl/feac_codeword.sv
module feac_codeword
  import feac_pkg::*;
#(
  parameter int CODE_WIDTH = CODE_W,
  parameter int ONES_WIDTH = ONES_W,
  localparam int CWIDTH    = CODE_WIDTH + 2 + ONES_WIDTH
) (
  input  logic [CODE_WIDTH-1:0] code_i,
  output logic [CWIDTH-1:0]     cw_o
);
  // slot 0 first: zero, code LSB first, zero, then the ones run
  genvar g;
  generate
    for (g = 0; g < CWIDTH; g++) begin : g_slot
      if (g == 0 || g == CODE_WIDTH + 1) begin : g_zero
        assign cw_o[g] = 1'b0;
      end else if (g <= CODE_WIDTH) begin : g_code
        assign cw_o[g] = code_i[g-1];
      end else begin : g_one
        assign cw_o[g] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/feac_serializer.sv
module feac_serializer
  import feac_pkg::*;
#(
  parameter int CODE_WIDTH = CODE_W,
  parameter int ONES_WIDTH = ONES_W,
  parameter int NREP       = REPEATS,
  localparam int CWIDTH    = CODE_WIDTH + 2 + ONES_WIDTH,
  localparam int IDX_W     = (CWIDTH > 1) ? $clog2(CWIDTH) : 1,
  localparam int REP_W     = (NREP > 1) ? $clog2(NREP) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable_i,
  input  logic                  start_i,
  input  logic [CODE_WIDTH-1:0] code_i,
  input  logic                  strobe_i,
  output logic                  bit_o,
  output logic                  done_o
);
  logic                  busy_q;
  logic [IDX_W-1:0]      idx_q;
  logic [REP_W-1:0]      rep_q;
  logic [CODE_WIDTH-1:0] code_q;
  logic [CWIDTH-1:0]     cw;

  feac_codeword #(.CODE_WIDTH(CODE_WIDTH), .ONES_WIDTH(ONES_WIDTH)) u_cw (
    .code_i (code_q),
    .cw_o   (cw)
  );

  logic last_slot, last_rep, accept;
  assign last_slot = (idx_q == IDX_W'(CWIDTH - 1));
  assign last_rep  = (rep_q == REP_W'(NREP - 1));
  assign accept    = enable_i && start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rep_q  <= '0;
      code_q <= '0;
      bit_o  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (strobe_i) begin
        if (busy_q && enable_i) begin
          bit_o <= cw[idx_q];
          if (last_slot) begin
            idx_q <= '0;
            if (last_rep) begin
              rep_q  <= '0;
              busy_q <= 1'b0;
              done_o <= 1'b1;
            end else begin
              rep_q <= rep_q + 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          bit_o <= 1'b1;
        end
      end
      if (!enable_i) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
        rep_q  <= '0;
      end else if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        rep_q  <= '0;
        code_q <= code_i;
      end
    end
  end

  p_idle_ones_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !busy_q) |=> bit_o);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(bit_o));
  p_rep_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rep_q < REP_W'(NREP));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_q && $past(busy_q)));
  p_code_held_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(code_q));
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!busy_q && !done_o));
endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_pkg::*;
#(
  parameter int CODE_WIDTH = CODE_W,
  parameter int ONES_WIDTH = ONES_W,
  parameter int NREP       = REPEATS,
  parameter int DWIDTH     = DATA_W,
  parameter int AWIDTH     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AWIDTH-1:0] addr,
  input  logic [DWIDTH-1:0] wr_data,
  output logic [DWIDTH-1:0] rd_data,
  input  logic              frame_strobe,
  output logic              feac_bit,
  output logic              irq
);
  logic [CODE_WIDTH-1:0] code;
  logic enable, start, done;

  feac_host_regs #(.CODE_WIDTH(CODE_WIDTH), .DWIDTH(DWIDTH), .AWIDTH(AWIDTH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .done_i   (done),
    .code_o   (code),
    .enable_o (enable),
    .start_o  (start),
    .irq_o    (irq)
  );

  feac_serializer #(.CODE_WIDTH(CODE_WIDTH), .ONES_WIDTH(ONES_WIDTH), .NREP(NREP)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .enable_i (enable),
    .start_i  (start),
    .code_i   (code),
    .strobe_i (frame_strobe),
    .bit_o    (feac_bit),
    .done_o   (done)
  );
endmodule

// File: tb/sim_feac_tx.sv
module sim_feac_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, frame_strobe = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic feac_bit, irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  feac_tx u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .frame_strobe(frame_strobe),
    .feac_bit(feac_bit), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [5:0] code, input int k);
    if (k == 0 || k == 7) return 1'b0;
    if (k <= 6) return code[k-1];
    return 1'b1;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic strobe();
    @(negedge clk); frame_strobe = 1'b1;
    @(negedge clk); frame_strobe = 1'b0;
  endtask

  task automatic send_check(input logic [5:0] code, input string req);
    for (int r = 0; r < 10; r++)
      for (int k = 0; k < 16; k++) begin
        strobe();
        chk(req, feac_bit, exp_bit(code, k));
      end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
        finish_sim();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 and R2: reset state
    chk("R1 reset bit", feac_bit, 1);
    chk("R7 reset irq", irq, 0);
    rd(2'd0, rv); chk("R2 reset code", rv, 0);
    rd(2'd1, rv); chk("R2 reset ctrl", rv, 0);
    rd(2'd2, rv); chk("R2 reset stat", rv, 0);
    for (int i = 0; i < 5; i++) begin strobe(); chk("R1 idle", feac_bit, 1); end

    // R2 readback, R3 start while disabled
    wr(2'd0, 8'h2A);
    rd(2'd0, rv); chk("R2 code readback", rv, 8'h2A);
    wr(2'd1, 8'h02);
    rd(2'd1, rv); chk("R2 ctrl readback", rv, 0);
    for (int i = 0; i < 16; i++) begin strobe(); chk("R3 disabled start", feac_bit, 1); end
    chk("R3 no irq", irq, 0);

    // R4/R5/R6/R8/R9: send 0x2A with pauses and disturbing writes
    wr(2'd1, 8'h03);
    rd(2'd1, rv); chk("R2 enable readback", rv, 1);
    for (int r = 0; r < 10; r++)
      for (int k = 0; k < 16; k++) begin
        strobe();
        chk("R4 R6 bit", feac_bit, exp_bit(6'h2A, k));
        if (r == 0 && k == 3) begin
          repeat (20) @(negedge clk);
          chk("R5 hold", feac_bit, exp_bit(6'h2A, k));
        end
        if (r == 2 && k == 5) begin
          wr(2'd0, 8'h15);
          wr(2'd1, 8'h03);   // R9 start while busy
          chk("R8 R9 hold", feac_bit, exp_bit(6'h2A, k));
        end
      end
    @(negedge clk); @(negedge clk);
    chk("R7 irq raised", irq, 1);
    for (int i = 0; i < 20; i++) begin strobe(); chk("R9 R1 idle after", feac_bit, 1); end
    rd(2'd2, rv); chk("R7 stat read", rv, 1);
    chk("R7 irq cleared", irq, 0);
    rd(2'd2, rv); chk("R7 stat reread", rv, 0);

    // R4/R6/R7 sweep of all codes
    for (int c = 0; c < 64; c++) begin
      wr(2'd0, 8'(c));
      wr(2'd1, 8'h03);
      chk("R7 irq low before", irq, 0);
      send_check(6'(c), "R4 R6 sweep");
      @(negedge clk); @(negedge clk);
      chk("R7 irq sweep", irq, 1);
      strobe(); chk("R6 idle sweep", feac_bit, 1);
      rd(2'd2, rv); chk("R7 clear sweep", rv, 1);
    end

    // R10 abort
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h03);
    for (int k = 0; k < 20; k++) begin
      strobe(); chk("R10 pre-abort", feac_bit, exp_bit(6'h00, k % 16));
    end
    wr(2'd1, 8'h00);
    for (int i = 0; i < 160; i++) begin strobe(); chk("R10 aborted idle", feac_bit, 1); end
    repeat (3) @(negedge clk);
    chk("R10 no irq", irq, 0);
    finish_sim();
  end
endmodule